// File: doc/BRIEF.md
# Frame-Rate Pixel Histogram Engine

This block counts how often each pixel value occurs in a video frame. Pixels arrive one per clock with a frame-start strobe. Each accepted pixel adds one to the bin whose index is its value. Two sets of bins alternate. While one set collects the current frame, the other holds the last finished frame, and a host reads it one bin per request. As the host reads bins in ascending order, the block also returns the cumulative histogram, a running total of all bins up to the one just read. Software therefore gets both forms for every frame at full frame rate.

A second mode counts edge directions. The pixel value is then a direction code with 180 legal values, one per two-degree step. A code is counted only when the gradient magnitude that comes with it is strictly greater than a threshold set through an input port. A region-of-interest enable can limit counting to part of the image. With 16-bit bins, a full 256 by 240 frame (61440 pixels) fits without overflow.

Top module: `frame_hist`

## Requirements
- R1: After reset every bin in both sets reads as zero, `rd_valid` is low, and `rd_cum` is zero.
- R2: In intensity mode (`dir_mode` low), every cycle with `pix_valid` and `roi_en` both high adds one to the bin indexed by `pix_data`.
- R3: In direction mode (`dir_mode` high), a pixel is counted only when `mag_data` is strictly greater than `mag_thresh`. The bin index is the direction code on `pix_data`.
- R4: In direction mode a code of 180 or more is discarded, so bins 180 to 255 stay unchanged.
- R5: A cycle with `pix_valid` low or `roi_en` low changes no bin.
- R6: A `sof` pulse swaps the two sets. The frame just collected becomes readable, and the other set is cleared to zero. A qualifying pixel in the same cycle as `sof` is the first count of the new frame.
- R7: When `rd_en` is high at a clock edge, `rd_valid` is high after that edge and `rd_count` holds the finished frame's bin `rd_addr`. After an edge with `rd_en` low, `rd_valid` is low. Pixels accumulating at the same time do not disturb the readout.
- R8: A read of address 0 loads `rd_cum` with bin 0. A read of any other address adds that bin to the previous `rd_cum`. Reading addresses 0 to 255 in order therefore returns the cumulative histogram.
- R9: A bin holds at 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Frame-start strobe, one cycle |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 8 | Pixel value or direction code |
| mag_data | input | 8 | Gradient magnitude for the pixel |
| mag_thresh | input | 8 | Magnitude threshold for direction mode |
| dir_mode | input | 1 | 1 selects direction mode, 0 intensity mode |
| roi_en | input | 1 | Pixel lies inside the region of interest |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 8 | Bin index to read |
| rd_valid | output | 1 | Read data valid |
| rd_count | output | 16 | Count of the bin read |
| rd_cum | output | 24 | Running sum of the bins read since address 0 |

## Verification
The assertions assume that `dir_mode` and `mag_thresh` stay constant within a frame. They also assume that the host does not request a read in the same cycle as `sof`. The cumulative properties assume that each readout begins at address 0. The bench changes the mode and the threshold only before a `sof`. Every read burst it issues starts at address 0 and is separated from frame starts by idle cycles. The only exception is a deliberate non-sequential probe of single bins, which the reference model follows with the same running-sum rule.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [0:0] {
    MODE_INTENSITY = 1'b0,
    MODE_DIRECTION = 1'b1
  } hist_mode_e;
endpackage

// File: rtl/hist_qualify.sv
module hist_qualify #(
  parameter int PIX_W    = 8,
  parameter int DIR_BINS = 180
) (
  input  logic             pix_valid,
  input  logic             roi_en,
  input  logic             dir_mode,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [PIX_W-1:0] mag_data,
  input  logic [PIX_W-1:0] mag_thresh,
  output logic             inc_en,
  output logic [PIX_W-1:0] inc_idx
);
  import hist_pkg::*;

  localparam logic [PIX_W-1:0] DIR_LIM = PIX_W'(DIR_BINS);

  hist_mode_e mode;
  logic       dir_ok;

  always_comb begin
    mode    = hist_mode_e'(dir_mode);
    dir_ok  = (pix_data < DIR_LIM) && (mag_data > mag_thresh);
    inc_idx = pix_data;
    inc_en  = pix_valid && roi_en;
    if (mode == MODE_DIRECTION) begin
      inc_en = inc_en && dir_ok;
    end
  end
endmodule

// File: rtl/hist_banks.sv
module hist_banks #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap,
  input  logic             inc_en,
  input  logic [PIX_W-1:0] inc_idx,
  input  logic [PIX_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_bin,
  output logic             bank_sel
);
  localparam int NBINS = 1 << PIX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] mem [2][NBINS];
  logic             bank_sel_nxt;
  logic             tgt_bank;

  always_comb begin
    bank_sel_nxt = swap ? ~bank_sel : bank_sel;
    tgt_bank     = bank_sel_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel <= 1'b0;
    end else if (swap) begin
      bank_sel <= bank_sel_nxt;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar i = 0; i < NBINS; i++) begin : g_bin
      logic             clr;
      logic             hit;
      logic [CNT_W-1:0] nxt;

      always_comb begin
        clr = swap && (bank_sel != 1'(b));
        hit = inc_en && (inc_idx == PIX_W'(i)) && (tgt_bank == 1'(b));
        nxt = mem[b][i];
        if (clr) begin
          nxt = '0;
        end
        if (hit && nxt != CNT_MAX) begin
          nxt = nxt + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[b][i] <= '0;
        end else if (clr || hit) begin
          mem[b][i] <= nxt;
        end
      end
    end
  end

  assign rd_bin = mem[~bank_sel][rd_addr];
endmodule

// File: rtl/hist_cum.sv
module hist_cum #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16,
  parameter int SUM_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [PIX_W-1:0] rd_addr,
  input  logic [CNT_W-1:0] rd_bin,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_count,
  output logic [SUM_W-1:0] rd_cum
);
  logic [SUM_W-1:0] cum_nxt;

  always_comb begin
    if (rd_addr == '0) begin
      cum_nxt = SUM_W'(rd_bin);
    end else begin
      cum_nxt = rd_cum + SUM_W'(rd_bin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_count <= '0;
      rd_cum   <= '0;
    end else if (rd_en) begin
      rd_count <= rd_bin;
      rd_cum   <= cum_nxt;
    end
  end
endmodule

// File: rtl/frame_hist.sv
module frame_hist #(
  parameter int PIX_W    = 8,
  parameter int CNT_W    = 16,
  parameter int DIR_BINS = 180,
  localparam int SUM_W   = CNT_W + PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [PIX_W-1:0] mag_data,
  input  logic [PIX_W-1:0] mag_thresh,
  input  logic             dir_mode,
  input  logic             roi_en,
  input  logic             rd_en,
  input  logic [PIX_W-1:0] rd_addr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_count,
  output logic [SUM_W-1:0] rd_cum
);
  logic             inc_en;
  logic [PIX_W-1:0] inc_idx;
  logic [CNT_W-1:0] rd_bin;
  logic             bank_sel;

  hist_qualify #(.PIX_W(PIX_W), .DIR_BINS(DIR_BINS)) u_qual (
    .pix_valid (pix_valid),
    .roi_en    (roi_en),
    .dir_mode  (dir_mode),
    .pix_data  (pix_data),
    .mag_data  (mag_data),
    .mag_thresh(mag_thresh),
    .inc_en    (inc_en),
    .inc_idx   (inc_idx)
  );

  hist_banks #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .swap    (sof),
    .inc_en  (inc_en),
    .inc_idx (inc_idx),
    .rd_addr (rd_addr),
    .rd_bin  (rd_bin),
    .bank_sel(bank_sel)
  );

  hist_cum #(.PIX_W(PIX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_cum (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_bin  (rd_bin),
    .rd_valid(rd_valid),
    .rd_count(rd_count),
    .rd_cum  (rd_cum)
  );
endmodule

// File: rtl/frame_hist_chk.sv
module frame_hist_chk #(
  parameter int PIX_W    = 8,
  parameter int CNT_W    = 16,
  parameter int DIR_BINS = 180,
  parameter int SUM_W    = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_data,
  input logic             dir_mode,
  input logic             roi_en,
  input logic             rd_en,
  input logic [PIX_W-1:0] rd_addr,
  input logic             rd_valid,
  input logic [CNT_W-1:0] rd_count,
  input logic [SUM_W-1:0] rd_cum,
  input logic             inc_en,
  input logic             bank_sel
);
  localparam logic [PIX_W-1:0] DIR_LIM = PIX_W'(DIR_BINS);

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  assert_cum_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == '0) |=> (rd_cum == SUM_W'(rd_count)));

  assert_cum_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != '0) |=> (rd_cum == $past(rd_cum) + SUM_W'(rd_count)));

  assert_cum_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_cum >= SUM_W'(rd_count)));

  assert_dir_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_mode && pix_data >= DIR_LIM) |-> !inc_en);

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid || !roi_en) |-> !inc_en);

  assert_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (bank_sel != $past(bank_sel)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(bank_sel));
endmodule

bind frame_hist frame_hist_chk #(
  .PIX_W(PIX_W), .CNT_W(CNT_W), .DIR_BINS(DIR_BINS), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .pix_valid(pix_valid),
  .pix_data(pix_data), .dir_mode(dir_mode), .roi_en(roi_en),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .rd_count(rd_count), .rd_cum(rd_cum), .inc_en(inc_en),
  .bank_sel(bank_sel)
);

// File: tb/frame_hist_tb.sv
module frame_hist_tb;
  logic       clk;
  logic       rst_n;
  logic       sof, pix_valid, dir_mode, roi_en, rd_en;
  logic [7:0] pix_data, mag_data, mag_thresh, rd_addr;
  logic       rd_valid;
  logic [15:0] rd_count;
  logic [23:0] rd_cum;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string req = "R1";

  int act [256];
  int done [256];
  int exp_valid, exp_count, exp_cum;

  frame_hist u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .pix_valid(pix_valid),
    .pix_data(pix_data), .mag_data(mag_data), .mag_thresh(mag_thresh),
    .dir_mode(dir_mode), .roi_en(roi_en), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_count(rd_count), .rd_cum(rd_cum)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference, updated with the inputs seen at each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin act[i] = 0; done[i] = 0; end
      exp_valid = 0; exp_count = 0; exp_cum = 0;
    end else begin
      exp_valid = rd_en ? 1 : 0;
      if (rd_en) begin
        exp_count = done[rd_addr];
        exp_cum = (rd_addr == 0) ? done[0] : exp_cum + done[rd_addr];
      end
      if (sof) begin
        for (int i = 0; i < 256; i++) begin done[i] = act[i]; act[i] = 0; end
      end
      if (pix_valid && roi_en &&
          (!dir_mode || (pix_data < 180 && mag_data > mag_thresh))) begin
        if (act[pix_data] < 65535) act[pix_data] = act[pix_data] + 1;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (int'(rd_valid) != exp_valid) begin
        bad++;
        $display("FAIL %s rd_valid actual=%0d expected=%0d", req, rd_valid, exp_valid);
      end
      if (exp_valid == 1) begin
        total++;
        if (int'(rd_count) != exp_count || int'(rd_cum) != exp_cum) begin
          bad++;
          $display("FAIL %s count/cum actual=%0d/%0d expected=%0d/%0d",
                   req, rd_count, rd_cum, exp_count, exp_cum);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sof = 0; pix_valid = 0; rd_en = 0; roi_en = 1;
    end
  endtask

  task automatic px(input logic v, input logic [7:0] p, input logic [7:0] m,
                    input logic roi, input logic s);
    @(negedge clk);
    sof = s; pix_valid = v; pix_data = p; mag_data = m; roi_en = roi; rd_en = 0;
  endtask

  // full ascending readout while unrelated pixels keep accumulating
  task automatic read_all();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      sof = 0; rd_en = 1; rd_addr = 8'(a);
      pix_valid = 1; roi_en = 1; pix_data = 8'(a * 3); mag_data = 8'd255;
    end
    idle(2);
  endtask

  task automatic read_one(input logic [7:0] a);
    @(negedge clk);
    sof = 0; pix_valid = 0; rd_en = 1; rd_addr = a;
    idle(1);
  endtask

  initial begin
    rst_n = 0; sof = 0; pix_valid = 0; pix_data = 0; mag_data = 0;
    mag_thresh = 8'd100; dir_mode = 0; roi_en = 1; rd_en = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset contents read as zero
    req = "R1"; idle(2);
    read_one(8'd0); read_one(8'd77);

    // R2: intensity ramp frame, R6: pixel on the sof cycle counts
    req = "R2";
    px(1, 8'd9, 0, 1, 1);
    for (int i = 0; i < 600; i++) px(1, 8'((i * 7) % 256), 0, 1, 0);
    // R5: gated pixels ignored
    req = "R5";
    for (int i = 0; i < 200; i++) px(i % 2 == 0, 8'(i % 16), 0, i % 3 != 0, 0);
    idle(2);
    req = "R6"; px(0, 0, 0, 1, 1); idle(2);
    // R8 / R7: cumulative readout during next frame
    req = "R8"; read_all();
    req = "R7"; read_one(8'd9); read_one(8'd0); read_one(8'd14);

    // R3 / R4: direction mode with threshold edges and out-of-range codes
    idle(2); dir_mode = 1; mag_thresh = 8'd100;
    req = "R3"; px(0, 0, 0, 1, 1);
    for (int i = 0; i < 400; i++)
      px(1, 8'((i * 11) % 256), 8'(98 + (i % 5)), 1, 0);
    req = "R4";
    for (int i = 0; i < 50; i++) px(1, 8'(179 + (i % 77)), 8'd200, 1, 0);
    idle(2);
    px(0, 0, 0, 1, 1); idle(2);
    req = "R3"; read_all();

    // R9: saturation of one bin
    dir_mode = 0; idle(2);
    req = "R9"; px(0, 0, 0, 1, 1);
    for (int i = 0; i < 65540; i++) px(1, 8'd42, 0, 1, 0);
    idle(2); px(0, 0, 0, 1, 1); idle(2);
    read_one(8'd0); read_one(8'd42); read_one(8'd41);
    req = "R6"; read_all();

    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule